// File: doc/BRIEF.md
# Addressable Eight-Output Latch Bank

This block keeps one on/off latch for each of eight low-side output channels. It drives one control line per channel. A 3-bit address picks one latch. While the active-low select is held low, the picked latch follows a single data bit on every clock. This lets software or a sequencer pulse-width modulate one channel by toggling data alone. When select goes high, the latch keeps its last value. Further address and data activity then has no effect.

Three controls act on all channels together:
- An active-low clear empties every latch.
- An active-high output enable blanks all lines without disturbing the stored pattern.
- An over-temperature flag also blanks all lines without disturbing the stored pattern.

Every input comes from outside the clock domain, so it passes through a two-stage synchronizer. The synchronizer comes out of reset holding the safe idle levels: address and data high, select low, clear active and enable inactive. As a result, a floating interface leaves every channel off.

Top module: `addr_latch_bank`

## Requirements
- R1: The address is binary, with bit 2 the most significant and bit 0 the least. Code n selects channel n, for n = 0..7.
- R2: While select is low, the addressed latch takes the data bit on every clock, so its channel follows data continuously.
- R3: While select is high, changes on address and data leave all latches unchanged.
- R4: A write changes only the addressed latch. The other seven keep their state, including during an address walk with select held low.
- R5: While clear is low, all latches go to off, whatever select, address and data are doing. Clear wins over a write in the same cycle.
- R6: While output enable is low, all channel lines are off. The latch contents are kept and reappear when enable returns high.
- R7: While over-temperature is high, all channel lines are off. The latch contents are kept and reappear when the flag drops.
- R8: An input change reaches the channel lines on the third rising clock edge after it is applied. This is two synchronizer stages plus one output register.
- R9: During and after reset, all channel lines are off. Until clear is released, they stay off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | 3 | Channel address, bit 2 most significant |
| dataIn | input | 1 | Value written to the addressed latch (1 = on) |
| csN | input | 1 | Active-low select; latch is transparent while low |
| clrN | input | 1 | Active-low clear of all latches |
| outEn | input | 1 | High lets channels follow latches; low blanks all |
| overTemp | input | 1 | High blanks all channels |
| chanOn | output | 8 | Per-channel on/off control, bit n = channel n |

## Verification
The bench builds the block with its defaults: eight channels and two synchronizer stages. Eight channels puts every address code in reach, as well as the full Gray-ordered walk that fills or empties the bank with select held low. Two stages give a fixed three-edge latency, which the behavioural queue model reproduces and checks on every clock. With these values, the bench can reach:
- clear colliding with an active write;
- blanking by enable and by over-temperature over a stored pattern;
- single-channel pulse-width modulation.

// File: rtl/alb_pkg.sv
package alb_pkg;

  // Bank-wide strobes from control to datapath
  typedef struct packed {
    logic writeEn;   // addressed latch takes dataBit this cycle
    logic clearAll;  // all latches go off (wins over writeEn)
    logic blankAll;  // outputs forced off, latches untouched
  } alb_strobe_t;

endpackage

// File: rtl/alb_sync.sv
module alb_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/alb_ctrl.sv
module alb_ctrl
  import alb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0] addrS,
  input  logic              dataS,
  input  logic              csNS,
  input  logic              clrNS,
  input  logic              outEnS,
  input  logic              overTempS,
  output alb_strobe_t       strb,
  output logic [NUM_CH-1:0] sel,
  output logic              dataBit
);

  // One-hot decode: code g selects channel g
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign sel[g] = (addrS == ADDR_W'(g));
  end

  always_comb begin
    strb.clearAll = !clrNS;
    strb.writeEn  = !csNS;
    strb.blankAll = !outEnS || overTempS;
  end

  assign dataBit = dataS;

endmodule

// File: rtl/alb_datapath.sv
module alb_datapath
  import alb_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  alb_strobe_t       strb,
  input  logic [NUM_CH-1:0] sel,
  input  logic              dataBit,
  output logic [NUM_CH-1:0] chanOn
);

  logic [NUM_CH-1:0] latchQ;
  logic [NUM_CH-1:0] latchNext;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_comb begin
      if (strb.clearAll)                 latchNext[g] = 1'b0;
      else if (strb.writeEn && sel[g])   latchNext[g] = dataBit;
      else                               latchNext[g] = latchQ[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      chanOn <= '0;
    end else begin
      latchQ <= latchNext;
      chanOn <= strb.blankAll ? '0 : latchNext;
    end
  end

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (latchQ == '0));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.writeEn && !strb.clearAll) |=> $stable(latchQ));

  // R4
  single_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeEn && !strb.clearAll) |=> ($countones(latchQ ^ $past(latchQ)) <= 1));

  // R2
  follow_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeEn && !strb.clearAll) |=>
      ((latchQ & $past(sel)) == ($past(dataBit) ? $past(sel) : '0)));

  // R7
  blank_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.blankAll |=> (chanOn == '0));

  // R6
  out_within_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((chanOn & ~latchQ) == '0));

endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import alb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataIn,
  input  logic              csN,
  input  logic              clrN,
  input  logic              outEn,
  input  logic              overTemp,
  output logic [NUM_CH-1:0] chanOn
);

  localparam int SYNC_W = ADDR_W + 5;
  // Safe idle levels: overTemp 0, outEn 0, clrN 0, csN 0, data 1, address all ones
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, {ADDR_W{1'b1}}};

  logic [SYNC_W-1:0] rawBus, syncBus;
  logic [ADDR_W-1:0] addrS;
  logic dataS, csNS, clrNS, outEnS, overTempS;
  alb_strobe_t strb;
  logic [NUM_CH-1:0] sel;
  logic dataBit;

  assign rawBus = {overTemp, outEn, clrN, csN, dataIn, addrIn};
  assign {overTempS, outEnS, clrNS, csNS, dataS, addrS} = syncBus;

  alb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .d(rawBus), .q(syncBus)
  );

  alb_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .addrS(addrS), .dataS(dataS), .csNS(csNS), .clrNS(clrNS),
    .outEnS(outEnS), .overTempS(overTempS),
    .strb(strb), .sel(sel), .dataBit(dataBit)
  );

  alb_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sel(sel),
    .dataBit(dataBit), .chanOn(chanOn)
  );

endmodule

// File: tb/addr_latch_bank_bench.sv
module addr_latch_bank_bench;

  localparam int NCH = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addrIn;
  logic dataIn, csN, clrN, outEn, overTemp;
  logic [NCH-1:0] chanOn;

  always #5 clk = ~clk;

  addr_latch_bank u_addr_latch_bank (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn), .csN(csN),
    .clrN(clrN), .outEn(outEn), .overTemp(overTemp), .chanOn(chanOn)
  );

  int vectors = 0;
  int fails = 0;
  string curReq = "R9";

  typedef struct {
    int addr;
    bit data;
    bit csN;
    bit clrN;
    bit outEn;
    bit ot;
  } snap_t;

  snap_t dflt = '{7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  snap_t q[$];
  logic [NCH-1:0] mLatch = '0;
  logic [NCH-1:0] mOut = '0;

  // Reference model: each input snapshot acts two edges later (R8)
  always @(posedge clk) begin
    snap_t s;
    if (!rstN) begin
      q.delete();
      q.push_back(dflt);
      q.push_back(dflt);
      mLatch = '0;
      mOut = '0;
    end else begin
      q.push_back('{int'(addrIn), dataIn, csN, clrN, outEn, overTemp});
      s = q.pop_front();
      if (!s.clrN) mLatch = '0;
      else if (!s.csN) mLatch[s.addr] = s.data;
      mOut = (s.outEn && !s.ot) ? mLatch : '0;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (chanOn !== mOut) begin
      fails++;
      $display("FAIL %s: chanOn=%b expected %b at %0t", curReq, chanOn, mOut, $time);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: chanOn=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input bit d);
    addrIn = AW'(a); dataIn = d; csN = 1'b0;
    step(2);
    csN = 1'b1;
    step(1);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R8: watchdog expired, actual=running expected=finished");
    finishRun();
  end

  initial begin
    int gray[8] = '{0, 1, 3, 2, 6, 7, 5, 4};
    addrIn = '1; dataIn = 1'b1; csN = 1'b0; clrN = 1'b0; outEn = 1'b0; overTemp = 1'b0;
    step(3);
    curReq = "R9";
    check("R9", chanOn, '0);
    rstN = 1'b1;
    step(4);
    check("R9", chanOn, '0);

    clrN = 1'b1; csN = 1'b1; outEn = 1'b1;
    step(4);

    // R1: individual codes land on matching channel
    curReq = "R1";
    wr(1, 1); wr(4, 1); wr(6, 1);
    step(4);
    check("R1", chanOn, 8'b0101_0010);
    for (int i = 0; i < NCH; i++) wr(i, (i % 3) == 0);
    step(4);
    check("R1", chanOn, 8'b0100_1001);

    // R8: latency of exactly three rising edges
    curReq = "R8";
    addrIn = 3'd5; dataIn = 1'b1; csN = 1'b0;
    step(2);
    check("R8", chanOn, 8'b0100_1001);
    step(1);
    check("R8", chanOn, 8'b0110_1001);
    csN = 1'b1;
    step(4);

    // R2: transparent following (PWM on channel 3)
    curReq = "R2";
    addrIn = 3'd3; csN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      dataIn = i[0];
      step(3);
    end
    dataIn = 1'b1;
    step(2);
    csN = 1'b1;
    step(4);
    check("R2", chanOn, 8'b0110_1001);

    // R3: ignored address/data while deselected
    curReq = "R3";
    for (int i = 0; i < 8; i++) begin
      addrIn = AW'(i); dataIn = ~i[0];
      step(1);
    end
    step(4);
    check("R3", chanOn, 8'b0110_1001);

    // R4: Gray walk with select held low, fill then empty
    curReq = "R4";
    csN = 1'b0; dataIn = 1'b1;
    foreach (gray[i]) begin addrIn = AW'(gray[i]); step(2); end
    csN = 1'b1;
    step(4);
    check("R4", chanOn, 8'hFF);
    addrIn = 3'd0; dataIn = 1'b0; csN = 1'b0;
    for (int i = 0; i < 4; i++) begin addrIn = AW'(gray[i]); step(2); end
    csN = 1'b1;
    step(4);
    check("R4", chanOn, 8'b1111_0000);

    // R5: clear beats an active write
    curReq = "R5";
    addrIn = 3'd2; dataIn = 1'b1; csN = 1'b0; clrN = 1'b0;
    step(4);
    check("R5", chanOn, '0);
    csN = 1'b1;
    step(1);
    clrN = 1'b1;
    step(4);
    check("R5", chanOn, '0);

    // R6: enable blanks but keeps contents
    curReq = "R6";
    wr(0, 1); wr(7, 1); wr(2, 1);
    step(4);
    outEn = 1'b0;
    step(4);
    check("R6", chanOn, '0);
    outEn = 1'b1;
    step(4);
    check("R6", chanOn, 8'b1000_0101);

    // R7: over-temperature blanks but keeps contents
    curReq = "R7";
    overTemp = 1'b1;
    step(2);
    wr(4, 1);
    step(3);
    check("R7", chanOn, '0);
    overTemp = 1'b0;
    step(4);
    check("R7", chanOn, 8'b1001_0101);

    step(2);
    finishRun();
  end

endmodule